// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

The selector looks at a level-sensitive vector of pending interrupt requests together with the processor state bits, the partition control enables and a halted indication. Each clock it chooses the one source that may be delivered now, or reports that none may. The choice is registered as a 5-bit source code with a valid flag, and a delivery sequencer downstream consumes it. Clearing requests, saving state and generating vectors are all left to the surrounding logic.

There are two selection paths. When the core is halted with the wake-control bit set, a short wake path runs. It considers only seven sources, each under its own enable and in its own order. Otherwise the normal path runs. There, most sources wait for an asynchronous-deliver condition. Some sources escape that gate through hypervisor rules: the hypervisor decrementer, the hypervisor virtualization interrupt and the external interrupt. A halted core with the wake-control bit clear uses the normal path with asynchronous delivery forced true. External reset beats everything in every mode.

Top module: `pend_irq_sel`

## Requirements
- R1: Request bit 0 (external reset) always yields code 0 with valid set, in every mode, including halted with wake control set.
- R2: The result appears on the outputs one clock after the inputs are sampled. The synchronous active-high reset clears valid and the code. When no source qualifies, valid is 0 and the code is 0.
- R3: Halted with wake control set, only these are considered, first match wins: external (bit 5, enable `wk_ext_en`), decrementer (bit 11, `wk_dec_en`), machine check (bit 1) then maintenance (bit 2), both under `wk_oth_en`, privileged doorbell (bit 12, `wk_pdb_en`), hypervisor doorbell (bit 13, `wk_hdb_en`), hypervisor virtualization (bit 4, `wk_hvi_en`). If none of them qualifies, the result is none.
- R4: In the wake path the external source is refused when `ext_hv_block`, `st_hv` are both 1 and `st_pr` is 0.
- R5: Halted with wake control clear, the normal path runs with asynchronous delivery forced true, whatever `st_ee` and `resume_rst` are.
- R6: On the normal path, machine check (bit 1) is taken right after reset and ignores every enable.
- R7: Hypervisor decrementer (bit 3, `hdec_en`) and then hypervisor virtualization (bit 4, `hvi_en`) are each taken when their enable is 1 and either asynchronous delivery (`st_ee` OR `resume_rst`) holds or `st_hv` is 0.
- R8: External (bit 5) is taken on the normal path when either of two conditions holds: asynchronous delivery holds and the R4 block condition is false, or `hv_capable`=1 with `st_hv`=0 and `part_sel0`=0.
- R9: Critical external (bit 6) is taken only when `st_ce`=1. It ranks after external.
- R10: With asynchronous delivery true, the remaining sources rank in this order: watchdog (7), critical doorbell (8), fixed-interval (9), programmable-interval (10), decrementer (11), privileged doorbell (12), hypervisor doorbell (13), performance monitor (14), thermal (15), event-based branch (16).
- R11: Event-based branch (bit 16) is taken only with `st_pr`=1 and `ebb_ge`=1.
- R12: Maintenance (bit 2) is never selected on the normal path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 17 | Pending request levels, bit index = source code |
| halted | input | 1 | Core is in a power-save halt |
| wake_ctl | input | 1 | Halt exit-criteria control |
| st_ee | input | 1 | State external-enable |
| st_hv | input | 1 | State hypervisor |
| st_pr | input | 1 | State problem (user) |
| st_ce | input | 1 | State critical-enable |
| resume_rst | input | 1 | Resume-as-reset flag |
| hv_capable | input | 1 | Hypervisor mode supported |
| part_sel0 | input | 1 | Partition environment select 0 |
| ext_hv_block | input | 1 | Block external to hypervisor |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| hvi_en | input | 1 | Hypervisor virtualization enable |
| wk_ext_en | input | 1 | Wake enable, external |
| wk_dec_en | input | 1 | Wake enable, decrementer |
| wk_oth_en | input | 1 | Wake enable, machine check / maintenance |
| wk_pdb_en | input | 1 | Wake enable, privileged doorbell |
| wk_hdb_en | input | 1 | Wake enable, hypervisor doorbell |
| wk_hvi_en | input | 1 | Wake enable, hypervisor virtualization |
| ebb_ge | input | 1 | Branch-event global enable |
| src_id | output | 5 | Selected source code |
| src_vld | output | 1 | A source was selected |

## Verification
Selection is purely combinational, and a single output register sits behind it, so every result is due at the first rising edge after the inputs are applied. The bench changes the inputs on the falling edge and lets one rising edge pass. It then compares `src_id` and `src_vld` one nanosecond after that edge against a reference function. It never looks later, because the next stimulus would already have replaced the result. Directed cases cover each gate and ordering rule, and seeded random patterns mix modes and sparse request vectors.

// File: rtl/pis_pkg.sv
package pis_pkg;
  localparam int NSRC = 17;
  localparam int ID_W = 5;

  typedef enum logic [ID_W-1:0] {
    SRC_RST   = 5'd0,
    SRC_MCK   = 5'd1,
    SRC_HMI   = 5'd2,
    SRC_HDEC  = 5'd3,
    SRC_HVI   = 5'd4,
    SRC_EXT   = 5'd5,
    SRC_CEXT  = 5'd6,
    SRC_WDT   = 5'd7,
    SRC_CDB   = 5'd8,
    SRC_FIT   = 5'd9,
    SRC_PIT   = 5'd10,
    SRC_DEC   = 5'd11,
    SRC_PDB   = 5'd12,
    SRC_HDB   = 5'd13,
    SRC_PERF  = 5'd14,
    SRC_THERM = 5'd15,
    SRC_EBB   = 5'd16
  } src_e;

  typedef struct packed {
    logic vld;
    src_e id;
  } pick_t;
endpackage

// File: rtl/pis_wake_sel.sv
module pis_wake_sel
  import pis_pkg::*;
(
  input  logic  r_ext,
  input  logic  r_dec,
  input  logic  r_mck,
  input  logic  r_hmi,
  input  logic  r_pdb,
  input  logic  r_hdb,
  input  logic  r_hvi,
  input  logic  en_ext,
  input  logic  en_dec,
  input  logic  en_oth,
  input  logic  en_pdb,
  input  logic  en_hdb,
  input  logic  en_hvi,
  input  logic  ext_blk,
  output pick_t pick
);
  always_comb begin
    pick = '{vld: 1'b0, id: SRC_RST};
    if (r_ext && en_ext && !ext_blk)  pick = '{vld: 1'b1, id: SRC_EXT};
    else if (r_dec && en_dec)         pick = '{vld: 1'b1, id: SRC_DEC};
    else if (r_mck && en_oth)         pick = '{vld: 1'b1, id: SRC_MCK};
    else if (r_hmi && en_oth)         pick = '{vld: 1'b1, id: SRC_HMI};
    else if (r_pdb && en_pdb)         pick = '{vld: 1'b1, id: SRC_PDB};
    else if (r_hdb && en_hdb)         pick = '{vld: 1'b1, id: SRC_HDB};
    else if (r_hvi && en_hvi)         pick = '{vld: 1'b1, id: SRC_HVI};
  end
endmodule

// File: rtl/pis_norm_sel.sv
module pis_norm_sel
  import pis_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  logic            async_ok,
  input  logic            st_hv,
  input  logic            st_pr,
  input  logic            st_ce,
  input  logic            hv_capable,
  input  logic            part_sel0,
  input  logic            ext_blk,
  input  logic            hdec_en,
  input  logic            hvi_en,
  input  logic            ebb_ge,
  output pick_t           pick
);
  logic [NSRC-1:0] qual;
  logic            hv_escape;

  assign hv_escape = async_ok || !st_hv;

  always_comb begin
    qual = req & {NSRC{async_ok}};
    qual[SRC_RST]  = req[SRC_RST];
    qual[SRC_MCK]  = req[SRC_MCK];
    qual[SRC_HDEC] = req[SRC_HDEC] && hdec_en && hv_escape;
    qual[SRC_HVI]  = req[SRC_HVI] && hvi_en && hv_escape;
    qual[SRC_EXT]  = req[SRC_EXT] &&
                     ((async_ok && !ext_blk) ||
                      (hv_capable && !st_hv && !part_sel0));
    qual[SRC_CEXT] = req[SRC_CEXT] && st_ce;
    qual[SRC_EBB]  = req[SRC_EBB] && async_ok && st_pr && ebb_ge;
  end

  always_comb begin
    pick = '{vld: 1'b0, id: SRC_RST};
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (qual[i]) pick = '{vld: 1'b1, id: src_e'(i[ID_W-1:0])};
    end
  end
endmodule

// File: rtl/pend_irq_sel.sv
module pend_irq_sel
  import pis_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      req,
  input  logic                 halted,
  input  logic                 wake_ctl,
  input  logic                 st_ee,
  input  logic                 st_hv,
  input  logic                 st_pr,
  input  logic                 st_ce,
  input  logic                 resume_rst,
  input  logic                 hv_capable,
  input  logic                 part_sel0,
  input  logic                 ext_hv_block,
  input  logic                 hdec_en,
  input  logic                 hvi_en,
  input  logic                 wk_ext_en,
  input  logic                 wk_dec_en,
  input  logic                 wk_oth_en,
  input  logic                 wk_pdb_en,
  input  logic                 wk_hdb_en,
  input  logic                 wk_hvi_en,
  input  logic                 ebb_ge,
  output logic [ID_W-1:0]      src_id,
  output logic                 src_vld
);
  localparam logic [NSRC-1:0] NORM_EXCL = NSRC'(1) << SRC_HMI;

  logic            wake_mode;
  logic            async_ok;
  logic            ext_blk;
  logic [NSRC-1:0] req_norm;
  pick_t           wake_pick;
  pick_t           norm_pick;
  pick_t           nxt;

  assign wake_mode = halted && wake_ctl;
  assign async_ok  = st_ee || resume_rst || (halted && !wake_ctl);
  assign ext_blk   = ext_hv_block && st_hv && !st_pr;
  assign req_norm  = req & ~NORM_EXCL;

  pis_wake_sel u_wake (
    .r_ext   (req[SRC_EXT]),
    .r_dec   (req[SRC_DEC]),
    .r_mck   (req[SRC_MCK]),
    .r_hmi   (req[SRC_HMI]),
    .r_pdb   (req[SRC_PDB]),
    .r_hdb   (req[SRC_HDB]),
    .r_hvi   (req[SRC_HVI]),
    .en_ext  (wk_ext_en),
    .en_dec  (wk_dec_en),
    .en_oth  (wk_oth_en),
    .en_pdb  (wk_pdb_en),
    .en_hdb  (wk_hdb_en),
    .en_hvi  (wk_hvi_en),
    .ext_blk (ext_blk),
    .pick    (wake_pick)
  );

  pis_norm_sel u_norm (
    .req        (req_norm),
    .async_ok   (async_ok),
    .st_hv      (st_hv),
    .st_pr      (st_pr),
    .st_ce      (st_ce),
    .hv_capable (hv_capable),
    .part_sel0  (part_sel0),
    .ext_blk    (ext_blk),
    .hdec_en    (hdec_en),
    .hvi_en     (hvi_en),
    .ebb_ge     (ebb_ge),
    .pick       (norm_pick)
  );

  always_comb begin
    if (req[SRC_RST])   nxt = '{vld: 1'b1, id: SRC_RST};
    else if (wake_mode) nxt = wake_pick;
    else                nxt = norm_pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_vld <= 1'b0;
      src_id  <= '0;
    end else begin
      src_vld <= nxt.vld;
      src_id  <= nxt.vld ? nxt.id : '0;
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    req[SRC_RST] |=> (src_vld && src_id == SRC_RST)); // R1
  AST_VALID_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    src_vld |-> ($past(req) != '0)); // R2
  AST_WAKE_SILENT: assert property (@(posedge clk) disable iff (rst)
    (wake_mode && !req[SRC_RST] && !wake_pick.vld) |=> !src_vld); // R3
  AST_MCK_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (!halted && req[SRC_MCK] && !req[SRC_RST]) |=> (src_vld && src_id == SRC_MCK)); // R6
  AST_NO_HMI_NORMAL: assert property (@(posedge clk) disable iff (rst)
    !wake_mode |=> (src_id != SRC_HMI)); // R12
  AST_ID_RANGE: assert property (@(posedge clk) disable iff (rst)
    src_vld |-> (src_id < NSRC)); // R2
endmodule

// File: tb/test_pend_irq_sel.sv
`timescale 1ns/1ps
module test_pend_irq_sel;
  logic        clk = 1'b0;
  logic        rst;
  logic [16:0] req;
  logic halted, wake_ctl, st_ee, st_hv, st_pr, st_ce, resume_rst, hv_capable;
  logic part_sel0, ext_hv_block, hdec_en, hvi_en, ebb_ge;
  logic wk_ext_en, wk_dec_en, wk_oth_en, wk_pdb_en, wk_hdb_en, wk_hvi_en;
  logic [4:0] src_id;
  logic       src_vld;
  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pend_irq_sel i_pend_irq_sel (
    .clk(clk), .rst(rst), .req(req), .halted(halted), .wake_ctl(wake_ctl),
    .st_ee(st_ee), .st_hv(st_hv), .st_pr(st_pr), .st_ce(st_ce),
    .resume_rst(resume_rst), .hv_capable(hv_capable), .part_sel0(part_sel0),
    .ext_hv_block(ext_hv_block), .hdec_en(hdec_en), .hvi_en(hvi_en),
    .wk_ext_en(wk_ext_en), .wk_dec_en(wk_dec_en), .wk_oth_en(wk_oth_en),
    .wk_pdb_en(wk_pdb_en), .wk_hdb_en(wk_hdb_en), .wk_hvi_en(wk_hvi_en),
    .ebb_ge(ebb_ge), .src_id(src_id), .src_vld(src_vld)
  );

  // reference model: returns {valid, code}
  function automatic logic [5:0] ref_sel();
    logic blk, asy, esc;
    blk = ext_hv_block && st_hv && !st_pr;
    if (req[0]) return {1'b1, 5'd0};
    if (halted && wake_ctl) begin
      if (req[5] && wk_ext_en && !blk) return {1'b1, 5'd5};
      if (req[11] && wk_dec_en) return {1'b1, 5'd11};
      if (req[1] && wk_oth_en) return {1'b1, 5'd1};
      if (req[2] && wk_oth_en) return {1'b1, 5'd2};
      if (req[12] && wk_pdb_en) return {1'b1, 5'd12};
      if (req[13] && wk_hdb_en) return {1'b1, 5'd13};
      if (req[4] && wk_hvi_en) return {1'b1, 5'd4};
      return 6'd0;
    end
    asy = st_ee || resume_rst || halted;
    esc = asy || !st_hv;
    if (req[1]) return {1'b1, 5'd1};
    if (req[3] && hdec_en && esc) return {1'b1, 5'd3};
    if (req[4] && hvi_en && esc) return {1'b1, 5'd4};
    if (req[5] && ((asy && !blk) || (hv_capable && !st_hv && !part_sel0)))
      return {1'b1, 5'd5};
    if (req[6] && st_ce) return {1'b1, 5'd6};
    if (asy) begin
      for (int k = 7; k <= 15; k++) if (req[k]) return {1'b1, 5'(k)};
      if (req[16] && st_pr && ebb_ge) return {1'b1, 5'd16};
    end
    return 6'd0;
  endfunction

  task automatic clear_in();
    req = '0; halted = 0; wake_ctl = 0; st_ee = 0; st_hv = 0; st_pr = 0;
    st_ce = 0; resume_rst = 0; hv_capable = 0; part_sel0 = 0; ext_hv_block = 0;
    hdec_en = 0; hvi_en = 0; ebb_ge = 0; wk_ext_en = 0; wk_dec_en = 0;
    wk_oth_en = 0; wk_pdb_en = 0; wk_hdb_en = 0; wk_hvi_en = 0;
  endtask

  task automatic check(input string tag, input logic [5:0] exp);
    checks++;
    if ({src_vld, src_id} !== exp) begin
      errors++;
      $display("FAIL %s: got vld=%0b id=%0d, expected vld=%0b id=%0d",
               tag, src_vld, src_id, exp[5], exp[4:0]);
    end
  endtask

  // inputs already set before the falling edge; one rising edge, then sample
  task automatic step_check(input string tag, input logic [5:0] exp);
    @(posedge clk); #1;
    check(tag, exp);
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    clear_in();
    rst = 1;
    req = 17'h1FFFF;
    @(negedge clk);
    @(posedge clk); #1;
    check("R2 reset state", 6'd0);
    @(negedge clk);
    rst = 0; clear_in();

    step_check("R2 no source", 6'd0);
    req = 17'h1FFFF; halted = 1; wake_ctl = 1;
    step_check("R1 reset in wake mode", {1'b1, 5'd0});
    clear_in(); halted = 1; wake_ctl = 1; req[5] = 1; req[11] = 1;
    wk_ext_en = 1; wk_dec_en = 1; ext_hv_block = 1; st_hv = 1;
    step_check("R4 ext blocked in wake", {1'b1, 5'd11});
    st_pr = 1;
    step_check("R4 ext unblocked in problem state", {1'b1, 5'd5});
    clear_in(); halted = 1; wake_ctl = 1; st_ee = 1; req[7] = 1; req[3] = 1;
    hdec_en = 1; req[2] = 1;
    step_check("R3 wake ignores others", 6'd0);
    wk_oth_en = 1; req[13] = 1; wk_hdb_en = 1;
    step_check("R3 maintenance before hyp doorbell", {1'b1, 5'd2});
    clear_in(); halted = 1; req[11] = 1;
    step_check("R5 halted forces async", {1'b1, 5'd11});
    clear_in(); req[1] = 1; req[7] = 1;
    step_check("R6 machine check without enable", {1'b1, 5'd1});
    clear_in(); req[3] = 1; hdec_en = 1; st_hv = 1;
    step_check("R7 hdec held in hv state", 6'd0);
    st_hv = 0;
    step_check("R7 hdec taken outside hv", {1'b1, 5'd3});
    clear_in(); req[5] = 1; hv_capable = 1;
    step_check("R8 ext via partition rule", {1'b1, 5'd5});
    part_sel0 = 1;
    step_check("R8 ext held by partition select", 6'd0);
    clear_in(); req[6] = 1;
    step_check("R9 critical without ce", 6'd0);
    st_ce = 1; req[7] = 1; st_ee = 1;
    step_check("R9 critical with ce", {1'b1, 5'd6});
    clear_in(); st_ee = 1; req[11] = 1; req[9] = 1; req[15] = 1;
    step_check("R10 fixed-interval before decrementer", {1'b1, 5'd9});
    clear_in(); resume_rst = 1; req[14] = 1; req[15] = 1;
    step_check("R10 perf before thermal", {1'b1, 5'd14});
    clear_in(); st_ee = 1; req[16] = 1; ebb_ge = 1;
    step_check("R11 branch event needs problem state", 6'd0);
    st_pr = 1;
    step_check("R11 branch event taken", {1'b1, 5'd16});
    clear_in(); st_ee = 1; req[2] = 1;
    step_check("R12 maintenance ignored normally", 6'd0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      req = 17'($urandom & $urandom & $urandom);
      if (($urandom % 8) != 0) req[0] = 1'b0;
      halted = r[0]; wake_ctl = r[1]; st_ee = r[2]; st_hv = r[3];
      st_pr = r[4]; st_ce = r[5]; resume_rst = r[6] & r[7];
      hv_capable = r[8]; part_sel0 = r[9]; ext_hv_block = r[10];
      hdec_en = r[11]; hvi_en = r[12]; ebb_ge = r[13]; wk_ext_en = r[14];
      wk_dec_en = r[15]; wk_oth_en = r[16]; wk_pdb_en = r[17];
      wk_hdb_en = r[18]; wk_hvi_en = r[19];
      if (req[0]) step_check("R1 random", ref_sel());
      else if (halted && wake_ctl) step_check("R3 random", ref_sel());
      else if (halted) step_check("R5 random", ref_sel());
      else step_check("R10 random", ref_sel());
    end

    rst = 1;
    step_check("R2 reset clears output", 6'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule